// File: doc/BRIEF.md
# Gated Timer/Counter Channel

This block is one timer/counter channel built from a low count byte and a high count byte. It can count in a 13-bit arrangement or in a full 16-bit arrangement. It has two count sources. As a timer, it counts pulses from a free-running divider on the system clock. As an event counter, it counts falling edges seen on an external count pin. A run bit switches counting on and off. A gate option also lets an external level pin hold the count still. With the gate on, the counter only advances while that pin is high, so software can measure how long the pin stays high.

Software reaches the channel through a small register port with four addresses. Address 0 is the low byte and address 1 is the high byte. Address 2 is the mode byte and address 3 holds run and status. The channel sets an overflow flag when the count wraps from all ones to zero. The flag drives the interrupt output and stays set until software clears it or an acknowledge pulse arrives. More than one channel can sit side by side. The `CH_IDX` parameter selects which nibble of the shared mode byte belongs to this channel.

Top module: `gtc_timer`

## Requirements
- R1: After reset, the low byte, the high byte, the mode byte and the run/status byte all read 0x00, and `ovf_irq` is 0.
- R2: In timer mode (mode select bit 2 = 0), the count source is a free-running divider that gives one count every `PRESCALE` (default 6) clocks. So any 60 consecutive clocks with run set add exactly 10 to the count.
- R3: While run (status bit 0) is 0, the count holds its value. Setting run again does not clear the count, and counting resumes from the held value.
- R4: In event mode (mode bit 2 = 1), `cnt_pin` passes through a two-stage synchronizer. Each falling edge then adds exactly one to the count, and rising edges add nothing.
- R5: Counting happens only while run is 1 and either the gate bit (mode bit 3) is 0 or the synchronized `gate_pin` is 1.
- R6: With mode bit 1 = 1, the two bytes form one 16-bit counter, with the high byte as the upper half. It wraps from 0xFFFF to 0x0000.
- R7: On a wrap from all ones to zero in either width, the overflow flag (status bit 1) is set and `ovf_irq` goes to 1.
- R8: With mode bit 1 = 0, only the low byte bits 4:0 and the whole high byte count. A step past 31 in the low five bits clears them and adds one to the high byte.
- R9: In 13-bit width, counting never changes low byte bits 7:5. They keep whatever software last wrote.
- R10: A write to the status address with bit 1 = 0 clears the overflow flag, and a write with bit 1 = 1 does not set it. If an overflow happens in the same cycle as the write, the flag stays set.
- R11: A one-cycle pulse on `irq_ack` clears the overflow flag, unless an overflow happens in that same cycle.
- R12: The mode byte holds this channel's fields in bits 4·CH_IDX+3 down to 4·CH_IDX: gate, event select and 16-bit width, with the nibble's bit 0 reserved. All other bits, including the reserved bit, read 0.
- R13: A write to either count byte wins over an increment in the same cycle. The written byte takes the written value, and neither byte advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source of the timer divider |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 low, 1 high, 2 mode, 3 run/status |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| cnt_pin | input | 1 | External count input, asynchronous |
| gate_pin | input | 1 | External gate level, asynchronous |
| irq_ack | input | 1 | Overflow acknowledge pulse, clears the flag |
| ovf_irq | output | 1 | Overflow flag, held until cleared |

## Verification
The bound checker watches several rules on every cycle. A write to a count byte must land, even against an increment. A stopped or gated-off count must not move. A 16-bit count may advance by at most one per cycle. Low byte bits 7:5 must keep their value while the width is 13-bit. A wrap must raise the interrupt, and an acknowledge must drop it. The directed scenarios cover what only a sequence of operations can show. They check the exact ratio of six clocks per count and that counting resumes after a stop. They check one count per falling pin edge and the carry from the five low bits into the high byte. They also check both wrap points, the clear and no-set behaviour of status writes, and where the mode nibble sits.

// File: rtl/gtc_pkg.sv
// Package gtc_pkg
// Shared register addresses and the mode field type for the gated
// timer/counter channel. It assumes a 2-bit register address.
package gtc_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    // Bit positions inside the status byte
    localparam int STAT_RUN_BIT  = 0;
    localparam int STAT_FLAG_BIT = 1;

    // Bit positions inside a channel's mode nibble
    localparam int NIB_WIDE_BIT = 1;
    localparam int NIB_EXT_BIT  = 2;
    localparam int NIB_GATE_BIT = 3;

    typedef struct packed {
        logic gate;   // external gate qualifies counting
        logic ext;    // 1: external pin edges, 0: divided clock
        logic wide;   // 1: 16-bit, 0: 13-bit
    } mode_t;

endpackage

// File: rtl/gtc_prescale.sv
// Module gtc_prescale
// A free-running clock divider. It gives a one-cycle tick once every DIV
// clocks and does not depend on run, mode or gate. Assumes DIV >= 2.
module gtc_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Step the phase counter and wrap at the last phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + CW'(1);
    end

    assign tick = (phase_q == LAST);

endmodule

// File: rtl/gtc_sync.sv
// Module gtc_sync
// A multi-stage synchronizer for one asynchronous level. Assumes the input
// stays at each level for longer than STAGES clocks. The output comes out
// STAGES clocks late and resets low.
module gtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value one stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gtc_count_core.sv
// Module gtc_count_core
// The two count bytes with a 13-bit or 16-bit increment. A byte write wins
// over an increment and stops both bytes from advancing in that cycle. In
// 13-bit width the low byte bits above LOW_BITS keep their value. Assumes
// at most one byte write per cycle.
module gtc_count_core #(
    parameter int W        = 8,
    parameter int LOW_BITS = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wide,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         wrap
);
    localparam int FULL_W = 2 * W;
    localparam logic [LOW_BITS-1:0] LOW_MAX = '1;

    logic [W-1:0]        lo_q, hi_q;
    logic [W-1:0]        lo_nx, hi_nx;
    logic [FULL_W-1:0]   full_inc;
    logic [LOW_BITS-1:0] low_inc;
    logic                low_carry;
    logic                at_top;
    logic                step;

    assign step = inc && !wr_lo && !wr_hi;

    // Work out the incremented value and the all-ones test for both widths
    always_comb begin
        full_inc  = {hi_q, lo_q} + FULL_W'(1);
        low_inc   = lo_q[LOW_BITS-1:0] + LOW_BITS'(1);
        low_carry = (lo_q[LOW_BITS-1:0] == LOW_MAX);
        if (wide) begin
            lo_nx  = full_inc[W-1:0];
            hi_nx  = full_inc[FULL_W-1:W];
            at_top = &{hi_q, lo_q};
        end else begin
            lo_nx  = {lo_q[W-1:LOW_BITS], low_inc};
            hi_nx  = low_carry ? hi_q + W'(1) : hi_q;
            at_top = (&hi_q) && low_carry;
        end
    end

    // Load a written byte, or otherwise step the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end else if (step) begin
            lo_q <= lo_nx;
            hi_q <= hi_nx;
        end
    end

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;
    assign wrap   = step && at_top;

endmodule

// File: rtl/gtc_timer.sv
// Module gtc_timer
// Top of one gated timer/counter channel. It holds the mode and run
// registers and the overflow flag, and it works out the count qualifier.
// It also decodes the four-address register port. Assumes CH_IDX is 0 or
// 1, which picks the channel's nibble inside the shared mode byte.
module gtc_timer
    import gtc_pkg::*;
#(
    parameter int PRESCALE    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int CH_IDX      = 0,
    parameter int LOW_BITS    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       cnt_pin,
    input  logic       gate_pin,
    input  logic       irq_ack,
    output logic       ovf_irq
);
    localparam int DW = 8;
    localparam int NB = 4 * CH_IDX;

    logic  wr_lo, wr_hi, wr_mode, wr_stat;
    mode_t mode_q;
    logic  run_q, flag_q;
    logic  cnt_lvl, cnt_prev_q, cnt_fall;
    logic  gate_lvl;
    logic  tick;
    logic  count_ok, src_pulse, inc;
    logic  wrap;
    logic [DW-1:0] cnt_lo, cnt_hi;

    // Decode the register writes
    assign wr_lo   = wr_en && (addr == ADDR_LO);
    assign wr_hi   = wr_en && (addr == ADDR_HI);
    assign wr_mode = wr_en && (addr == ADDR_MODE);
    assign wr_stat = wr_en && (addr == ADDR_STAT);

    // Load the mode fields from this channel's nibble
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_mode) begin
            mode_q.gate <= wdata[NB + NIB_GATE_BIT];
            mode_q.ext  <= wdata[NB + NIB_EXT_BIT];
            mode_q.wide <= wdata[NB + NIB_WIDE_BIT];
        end
    end

    // Load the run bit from the status address
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (wr_stat) run_q <= wdata[STAT_RUN_BIT];
    end

    gtc_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnt_pin), .sync_out(cnt_lvl)
    );

    gtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_in(gate_pin), .sync_out(gate_lvl)
    );

    // Keep the last synchronized pin level so a falling edge can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_prev_q <= 1'b0;
        else        cnt_prev_q <= cnt_lvl;
    end

    assign cnt_fall = cnt_prev_q && !cnt_lvl;

    gtc_prescale #(.DIV(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // Qualify the chosen source with run and gate
    assign count_ok  = run_q && (!mode_q.gate || gate_lvl);
    assign src_pulse = mode_q.ext ? cnt_fall : tick;
    assign inc       = count_ok && src_pulse;

    gtc_count_core #(.W(DW), .LOW_BITS(LOW_BITS)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wide(mode_q.wide),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap(wrap)
    );

    // Overflow flag: a wrap sets it and wins over both ways of clearing it
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wrap)
            flag_q <= 1'b1;
        else if (irq_ack || (wr_stat && !wdata[STAT_FLAG_BIT]))
            flag_q <= 1'b0;
    end

    assign ovf_irq = flag_q;

    // Select the read data for the current address
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_LO:   rdata = cnt_lo;
            ADDR_HI:   rdata = cnt_hi;
            ADDR_MODE: begin
                rdata[NB + NIB_GATE_BIT] = mode_q.gate;
                rdata[NB + NIB_EXT_BIT]  = mode_q.ext;
                rdata[NB + NIB_WIDE_BIT] = mode_q.wide;
            end
            default: begin
                rdata[STAT_RUN_BIT]  = run_q;
                rdata[STAT_FLAG_BIT] = flag_q;
            end
        endcase
    end

endmodule

// File: rtl/gtc_timer_chk.sv
// Module gtc_timer_chk
// Rules checked on every cycle for gtc_timer. It is bound to the top and
// sees its port and register signals. Assumes the default byte width of 8.
module gtc_timer_chk
    import gtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       irq_ack,
    input logic       ovf_irq,
    input logic       run_q,
    input logic       gate_on,
    input logic       gate_lvl,
    input logic       wide,
    input logic       wrap,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi
);
    AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_LO) |=> (cnt_lo == $past(wdata))); // R13

    AST_HI_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_HI) |=> (cnt_hi == $past(wdata))); // R13

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> $stable({cnt_hi, cnt_lo})); // R3

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !gate_lvl && !wr_en) |=> $stable({cnt_hi, cnt_lo})); // R5

    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && wide) |=> ($stable({cnt_hi, cnt_lo}) ||
            {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 16'd1)); // R6

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wide) |=> $stable(cnt_lo[7:5])); // R9

    AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_irq); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wrap) |=> !ovf_irq); // R11

endmodule

bind gtc_timer gtc_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_ack(irq_ack), .ovf_irq(ovf_irq), .run_q(run_q),
    .gate_on(mode_q.gate), .gate_lvl(gate_lvl), .wide(mode_q.wide),
    .wrap(wrap), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/gtc_timer_tb.sv
// Directed bench for gtc_timer: one task per scenario, each checking itself.
module gtc_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cnt_pin = 1'b1;
    logic       gate_pin = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gtc_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .irq_ack(irq_ack), .ovf_irq(ovf_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cnt_pin = 1'b0;
            repeat (4) @(negedge clk);
            cnt_pin = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic read_count(output int v);
        logic [7:0] lo, hi;
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            reg_rd(a[1:0], d);
            check("R1 reset register", d, 0);
        end
        check("R1 reset irq", ovf_irq, 0);
    endtask

    task automatic t_timer_and_hold;
        int v;
        reg_wr(2'd2, 8'h02);             // timer source, 16-bit
        reg_wr(2'd3, 8'h03);             // run
        repeat (59) @(posedge clk);
        reg_wr(2'd3, 8'h02);             // stop after 60 clocks
        read_count(v);
        check("R2 sixty clocks give ten counts", v, 10);
        repeat (30) @(negedge clk);
        read_count(v);
        check("R3 stopped count holds", v, 10);
        reg_wr(2'd3, 8'h03);
        repeat (59) @(posedge clk);
        reg_wr(2'd3, 8'h02);
        read_count(v);
        check("R3 restart resumes from held value", v, 20);
    endtask

    task automatic t_event_count;
        int v;
        reg_wr(2'd2, 8'h06);             // external pin, 16-bit
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd3, 8'h03);
        pulse_pin(5);
        read_count(v);
        check("R4 five falling edges", v, 5);
    endtask

    task automatic t_gate;
        int v;
        reg_wr(2'd2, 8'h0E);             // gate on, external pin, 16-bit
        reg_wr(2'd0, 8'h00);
        gate_pin = 1'b0;
        repeat (4) @(negedge clk);
        pulse_pin(3);
        read_count(v);
        check("R5 gate low blocks counts", v, 0);
        gate_pin = 1'b1;
        repeat (4) @(negedge clk);
        pulse_pin(3);
        read_count(v);
        check("R5 gate high lets counts through", v, 3);
        reg_wr(2'd2, 8'h06);
    endtask

    task automatic t_wrap16;
        int v;
        logic [7:0] s;
        reg_wr(2'd0, 8'hFF);
        reg_wr(2'd1, 8'hFF);
        pulse_pin(1);
        read_count(v);
        check("R6 16-bit wrap to zero", v, 0);
        check("R7 irq after 16-bit wrap", ovf_irq, 1);
        reg_rd(2'd3, s);
        check("R7 status shows flag", s, 8'h03);
        reg_wr(2'd3, 8'h03);
        check("R10 writing one leaves flag", ovf_irq, 1);
        reg_wr(2'd3, 8'h01);
        check("R10 writing zero clears flag", ovf_irq, 0);
        reg_wr(2'd3, 8'h03);
        check("R10 writing one does not set flag", ovf_irq, 0);
    endtask

    task automatic t_thirteen;
        logic [7:0] lo, hi;
        reg_wr(2'd2, 8'h04);             // external pin, 13-bit
        reg_wr(2'd0, 8'hFF);
        reg_wr(2'd1, 8'h12);
        pulse_pin(1);
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        check("R8 high byte takes carry", hi, 8'h13);
        check("R9 low bits 7:5 kept, 4:0 cleared", lo, 8'hE0);
        check("R8 no flag on inner carry", ovf_irq, 0);
        reg_wr(2'd0, 8'h1F);
        reg_wr(2'd1, 8'hFF);
        pulse_pin(1);
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        check("R7 13-bit wrap high", hi, 0);
        check("R7 13-bit wrap low", lo, 0);
        check("R7 irq after 13-bit wrap", ovf_irq, 1);
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
        check("R11 ack clears flag", ovf_irq, 0);
    endtask

    task automatic t_collision;
        logic [7:0] lo, hi;
        reg_wr(2'd2, 8'h06);
        reg_wr(2'd0, 8'h10);
        reg_wr(2'd1, 8'h20);
        @(negedge clk) cnt_pin = 1'b0;
        @(posedge clk);
        @(posedge clk);                  // edge is now seen; count lands next
        reg_wr(2'd0, 8'h55);
        repeat (4) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (6) @(negedge clk);
        reg_rd(2'd0, lo);
        reg_rd(2'd1, hi);
        check("R13 written low byte wins", lo, 8'h55);
        check("R13 high byte not advanced", hi, 8'h20);
    endtask

    task automatic t_mode_map;
        logic [7:0] d;
        reg_wr(2'd3, 8'h02);             // stop
        reg_wr(2'd2, 8'hFF);
        reg_rd(2'd2, d);
        check("R12 mode nibble readback", d, 8'h0E);
        reg_wr(2'd2, 8'hF0);
        reg_rd(2'd2, d);
        check("R12 other nibble ignored", d, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer_and_hold();
        t_event_count();
        t_gate();
        t_wrap16();
        t_thirteen();
        t_collision();
        t_mode_map();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule